// File: doc/BRIEF.md
# Dual-Mode Dual-Clock FIFO Core

This block moves 18-bit words from a write clock domain to an unrelated read clock domain. A mode pin, captured while reset is held low, picks one of two behaviours. In standard mode the reader must ask for a word before it appears on `q`. The write-side flag means "not full" and the read-side flag means "not empty". In fall-through mode the head word appears on `q` by itself. A dedicated output register holds that word, which raises the capacity to DEPTH+1 words. In this mode the write-side flag means "no room" and the read-side flag means "no word shown".

The write and read pointers cross between domains as Gray code through two-stage synchronisers. Each flag is therefore computed from registers in its own clock domain. A flag can lag behind the true state, but only in the safe direction.

Top module: `dm_async_fifo`

## Requirements
- R1: Standard mode (mode pin low at reset): `fullIr` is 1 while the FIFO holds fewer than DEPTH words and goes to 0 on the write-clock edge that stores word number DEPTH, with no reads since reset; it returns to 1 after words are read and the read pointer has crossed over.
- R2: Standard mode: a write (write-clock edge with `wEnN` = 0) while `fullIr` is 0 stores nothing, so exactly DEPTH words can be read back afterwards.
- R3: Fall-through mode (mode pin high at reset): `fullIr` is 0 while room exists and goes to 1 only after DEPTH+1 words are held (DEPTH in memory plus one on `q`); writes while it is 1 store nothing.
- R4: Standard mode: `emptyOr` is 0 while no word is stored; a read (read-clock edge with `rEnN` = 0) while it is 0 leaves `q` unchanged.
- R5: Standard mode: a read while `emptyOr` is 1 places the oldest stored word on `q` at that read-clock edge; without a read, `q` holds.
- R6: Fall-through mode: `emptyOr` goes to 0 on the same read-clock edge on which the first word written into an empty FIFO appears on `q`, with `rEnN` held at 1.
- R7: Fall-through mode: while `emptyOr` is 0 and no read is made, `emptyOr` stays 0 and `q` holds; a read replaces `q` with the next word or, if none is stored, sets `emptyOr` to 1.
- R8: Fall-through mode: after the last word has been read, `q` keeps that word and reads made while `emptyOr` is 1 change neither `q` nor the flags.
- R9: While `rstN` is 0 both pointers clear and the mode pin is sampled on each clock. Afterwards standard mode shows `fullIr`=1 and `emptyOr`=0, and fall-through mode shows `fullIr`=0 and `emptyOr`=1. Changing the mode pin after reset has no effect.
- R10: With writes and reads running together on unrelated clocks, every stored word is delivered once and in write order, in both modes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wClk | input | 1 | Write clock |
| rClk | input | 1 | Read clock |
| rstN | input | 1 | Active-low reset for both domains; mode pin sampled while low |
| fwftSel | input | 1 | 1 selects fall-through mode, 0 standard mode |
| wEnN | input | 1 | Active-low write enable |
| din | input | DATA_W | Write data |
| fullIr | output | 1 | Standard: 1 = not full; fall-through: 1 = no room |
| rEnN | input | 1 | Active-low read enable |
| emptyOr | output | 1 | Standard: 1 = not empty; fall-through: 0 = valid word on `q` |
| q | output | DATA_W | Read data |

## Verification
On every cycle, the assertions check several properties. Writes and reads are refused whenever the matching flag forbids them. In standard mode `q` never moves without a read. In fall-through mode a shown word stays in place until a read, and an idle output keeps its last word. Other behaviours need the bench's scenarios. These include the exact write count at which each flag switches in each mode, the point at which the first fall-through word appears, the capture of the mode pin at reset, and end-to-end word order under overlapping traffic on two clocks. A scoreboard checks these against its own queue.

// File: rtl/fifo_pkg.sv
package fifo_pkg;
  // strobes from control to datapath; each field belongs to one clock domain
  typedef struct packed {
    logic memWr;   // write-clock domain: store din
    logic qLoad;   // read-clock domain: load the head word into q
  } strobe_t;
endpackage

// File: rtl/fifo_gray_sync.sv
module fifo_gray_sync #(
  parameter int W      = 5,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] dIn,
  output logic [W-1:0] dOut
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stg <= '0;
    else       stg <= {stg[STAGES-2:0], dIn};
  end

  assign dOut = stg[STAGES-1];
endmodule

// File: rtl/fifo_ctrl.sv
module fifo_ctrl #(
  parameter int ADDR_W = 4
) (
  input  logic              wClk,
  input  logic              rClk,
  input  logic              rstN,
  input  logic              fwftSel,
  input  logic              wEnN,
  input  logic              rEnN,
  output fifo_pkg::strobe_t strb,
  output logic [ADDR_W-1:0] wAddr,
  output logic [ADDR_W-1:0] rAddr,
  output logic              fullIr,
  output logic              emptyOr,
  output logic              wMode,
  output logic              rMode
);
  localparam int PW = ADDR_W + 1;

  function automatic logic [PW-1:0] toGray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  // ---------------- write domain ----------------
  logic [PW-1:0] wBin, wGray, rGraySync;
  logic          wFull, doWrite;

  always_ff @(posedge wClk) begin
    if (!rstN) wMode <= fwftSel;
  end

  assign wFull   = (wGray == {~rGraySync[PW-1:PW-2], rGraySync[PW-3:0]});
  assign doWrite = !wEnN && !wFull;

  always_ff @(posedge wClk or negedge rstN) begin
    if (!rstN) begin
      wBin  <= '0;
      wGray <= '0;
    end else if (doWrite) begin
      wBin  <= wBin + 1'b1;
      wGray <= toGray(wBin + 1'b1);
    end
  end

  // ---------------- read domain ----------------
  logic [PW-1:0] rBin, rGray, wGraySync;
  logic          rEmpty, outValid, stdLoad, fwftLoad, qLoad;

  always_ff @(posedge rClk) begin
    if (!rstN) rMode <= fwftSel;
  end

  assign rEmpty   = (rGray == wGraySync);
  assign stdLoad  = !rMode && !rEnN && !rEmpty;
  assign fwftLoad = rMode && !rEmpty && (!outValid || !rEnN);
  assign qLoad    = stdLoad || fwftLoad;

  always_ff @(posedge rClk or negedge rstN) begin
    if (!rstN) begin
      rBin  <= '0;
      rGray <= '0;
    end else if (qLoad) begin
      rBin  <= rBin + 1'b1;
      rGray <= toGray(rBin + 1'b1);
    end
  end

  always_ff @(posedge rClk or negedge rstN) begin
    if (!rstN)         outValid <= 1'b0;
    else if (fwftLoad) outValid <= 1'b1;
    else if (!rEnN)    outValid <= 1'b0;
  end

  // ---------------- crossings ----------------
  fifo_gray_sync #(.W(PW), .STAGES(2)) u_rToW (
    .clk(wClk), .rstN(rstN), .dIn(rGray), .dOut(rGraySync)
  );
  fifo_gray_sync #(.W(PW), .STAGES(2)) u_wToR (
    .clk(rClk), .rstN(rstN), .dIn(wGray), .dOut(wGraySync)
  );

  // ---------------- outputs ----------------
  assign strb.memWr = doWrite;
  assign strb.qLoad = qLoad;
  assign wAddr      = wBin[ADDR_W-1:0];
  assign rAddr      = rBin[ADDR_W-1:0];
  assign fullIr     = wMode ? wFull : !wFull;
  assign emptyOr    = rMode ? !outValid : !rEmpty;
endmodule

// File: rtl/fifo_datapath.sv
module fifo_datapath #(
  parameter int DATA_W = 18,
  parameter int ADDR_W = 4
) (
  input  logic              wClk,
  input  logic              rClk,
  input  logic              rstN,
  input  fifo_pkg::strobe_t strb,
  input  logic [ADDR_W-1:0] wAddr,
  input  logic [ADDR_W-1:0] rAddr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] q
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge wClk) begin
    if (strb.memWr) mem[wAddr] <= din;
  end

  always_ff @(posedge rClk or negedge rstN) begin
    if (!rstN)           q <= '0;
    else if (strb.qLoad) q <= mem[rAddr];
  end
endmodule

// File: rtl/dm_async_fifo.sv
module dm_async_fifo #(
  parameter int DATA_W = 18,
  parameter int ADDR_W = 4
) (
  input  logic              wClk,
  input  logic              rClk,
  input  logic              rstN,
  input  logic              fwftSel,
  input  logic              wEnN,
  input  logic [DATA_W-1:0] din,
  output logic              fullIr,
  input  logic              rEnN,
  output logic              emptyOr,
  output logic [DATA_W-1:0] q
);
  fifo_pkg::strobe_t strb;
  logic [ADDR_W-1:0] wAddr, rAddr;
  logic              wMode, rMode;

  fifo_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .wClk(wClk), .rClk(rClk), .rstN(rstN), .fwftSel(fwftSel),
    .wEnN(wEnN), .rEnN(rEnN), .strb(strb), .wAddr(wAddr), .rAddr(rAddr),
    .fullIr(fullIr), .emptyOr(emptyOr), .wMode(wMode), .rMode(rMode)
  );

  fifo_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dp (
    .wClk(wClk), .rClk(rClk), .rstN(rstN), .strb(strb),
    .wAddr(wAddr), .rAddr(rAddr), .din(din), .q(q)
  );
endmodule

// File: rtl/dm_async_fifo_chk.sv
module dm_async_fifo_chk #(
  parameter int DATA_W = 18
) (
  input logic              wClk,
  input logic              rClk,
  input logic              rstN,
  input logic              wEnN,
  input logic              rEnN,
  input logic              fullIr,
  input logic              emptyOr,
  input logic [DATA_W-1:0] q,
  input logic              wMode,
  input logic              rMode,
  input logic              memWr,
  input logic              qLoad
);
  // R2
  std_full_blocks_write_chk: assert property (@(posedge wClk) disable iff (!rstN)
    (!wMode && !fullIr && !wEnN) |-> !memWr);

  // R3
  fwft_ir_blocks_write_chk: assert property (@(posedge wClk) disable iff (!rstN)
    (wMode && fullIr && !wEnN) |-> !memWr);

  // R4
  std_empty_blocks_read_chk: assert property (@(posedge rClk) disable iff (!rstN)
    (!rMode && !emptyOr) |-> !qLoad);

  // R5
  std_q_hold_chk: assert property (@(posedge rClk) disable iff (!rstN)
    (!rMode && rEnN) |=> $stable(q));

  // R7
  fwft_ready_holds_chk: assert property (@(posedge rClk) disable iff (!rstN)
    (rMode && !emptyOr && rEnN) |=> (!emptyOr && $stable(q)));

  // R8
  fwft_idle_q_hold_chk: assert property (@(posedge rClk) disable iff (!rstN)
    (rMode && emptyOr) |=> (!emptyOr || $stable(q)));
endmodule

bind dm_async_fifo dm_async_fifo_chk #(.DATA_W(DATA_W)) u_chk (
  .wClk(wClk), .rClk(rClk), .rstN(rstN), .wEnN(wEnN), .rEnN(rEnN),
  .fullIr(fullIr), .emptyOr(emptyOr), .q(q), .wMode(wMode), .rMode(rMode),
  .memWr(strb.memWr), .qLoad(strb.qLoad)
);

// File: tb/dm_async_fifo_bench.sv
module dm_async_fifo_bench;
  localparam int W_PERIOD = 10;
  localparam int R_PERIOD = 14;
  localparam int DATA_W   = 18;
  localparam int ADDR_W   = 4;
  localparam int DEPTH    = 1 << ADDR_W;

  logic wClk = 0, rClk = 0;
  logic rstN = 0, fwftSel = 0, wEnN = 1, rEnN = 1;
  logic [DATA_W-1:0] din = '0;
  logic fullIr, emptyOr;
  logic [DATA_W-1:0] q;

  always #(W_PERIOD/2) wClk = ~wClk;
  always #(R_PERIOD/2) rClk = ~rClk;

  dm_async_fifo #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dm_async_fifo (
    .wClk(wClk), .rClk(rClk), .rstN(rstN), .fwftSel(fwftSel), .wEnN(wEnN),
    .din(din), .fullIr(fullIr), .rEnN(rEnN), .emptyOr(emptyOr), .q(q)
  );

  int nCmp = 0, nBad = 0;
  bit fw = 0;
  bit done = 0;
  logic [DATA_W-1:0] expQ[$];
  logic [DATA_W-1:0] lastQ = '0;

  task automatic chk(bit ok, string req, string what, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
    nCmp++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic doReset(bit mode);
    fwftSel = mode;
    fw = mode;
    rstN = 0; wEnN = 1; rEnN = 1;
    expQ.delete();
    repeat (5) @(negedge rClk);
    @(negedge wClk);
    rstN = 1;
  endtask

  // driver: pushes accepted words into the scoreboard queue
  task automatic writeN(int n, logic [DATA_W-1:0] base, int gap);
    int i;
    bit space;
    i = 0;
    while (i < n) begin
      @(negedge wClk);
      if (gap > 0 && (i % gap) == gap - 1 && wEnN == 0) begin
        wEnN = 1;
        @(negedge wClk);
      end
      din   = base + DATA_W'(i * 37);
      wEnN  = 0;
      space = fw ? !fullIr : fullIr;
      @(posedge wClk);
      if (space) begin
        expQ.push_back(din);
        i++;
      end
    end
    @(negedge wClk);
    wEnN = 1;
  endtask

  // monitor: reads n words and compares them against the queue
  task automatic drainMon(int n, string tag);
    int got;
    bit pend;
    logic [DATA_W-1:0] e;
    got = 0;
    pend = 0;
    while (got < n || pend) begin
      @(negedge rClk);
      if (pend) begin
        e = (expQ.size() > 0) ? expQ.pop_front() : '0;
        chk(q == e, tag, "std read word", q, e);
        lastQ = e;
        got++;
        pend = 0;
      end
      if (fw) begin
        if (got < n && !emptyOr) begin
          e = (expQ.size() > 0) ? expQ.pop_front() : '0;
          chk(q == e, tag, "fall-through head word", q, e);
          lastQ = e;
          got++;
          rEnN = 0;
        end else rEnN = 1;
      end else begin
        if (got < n && emptyOr) begin
          rEnN = 0;
          pend = 1;
        end else rEnN = 1;
      end
    end
    @(negedge rClk);
    rEnN = 1;
  endtask

  initial begin
    #(W_PERIOD * 150000);
    if (!done) begin
      nCmp++;
      nBad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

  initial begin
    // ================= standard mode =================
    doReset(0);
    @(negedge wClk);
    chk(fullIr == 1, "R9", "std fullIr after reset", fullIr, 1);
    @(negedge rClk);
    chk(emptyOr == 0, "R9", "std emptyOr after reset", emptyOr, 0);
    fwftSel = 1;   // must not change the mode (R9)

    // R4: reads while empty are ignored
    rEnN = 0;
    repeat (4) @(negedge rClk);
    rEnN = 1;
    chk(q == 0, "R4", "q after reads on empty", q, 0);
    chk(emptyOr == 0, "R4", "emptyOr still low", emptyOr, 0);

    // R9: a single word does not fall through after the mode pin changed
    writeN(1, 18'h00100, 0);
    repeat (6) @(negedge rClk);
    chk(emptyOr == 1, "R9", "std emptyOr after one write", emptyOr, 1);
    chk(q == 0, "R9", "no fall-through in std mode", q, 0);

    // R1: full after exactly DEPTH writes
    writeN(DEPTH - 2, 18'h00200, 0);
    chk(fullIr == 1, "R1", "fullIr after DEPTH-1 writes", fullIr, 1);
    writeN(1, 18'h03000, 0);
    chk(fullIr == 0, "R1", "fullIr after DEPTH writes", fullIr, 0);

    // R2: writes while full are dropped
    repeat (3) begin
      @(negedge wClk);
      din = 18'h3ffff;
      wEnN = 0;
    end
    @(negedge wClk);
    wEnN = 1;
    chk(fullIr == 0, "R2", "fullIr stays low on overflow", fullIr, 0);

    // R5: ordered read-out of exactly DEPTH words
    drainMon(DEPTH, "R5");
    chk(emptyOr == 0, "R2", "empty after DEPTH reads", emptyOr, 0);
    repeat (6) @(negedge wClk);
    chk(fullIr == 1, "R1", "fullIr back high after reads", fullIr, 1);

    // R10: overlapping traffic
    fork
      writeN(48, 18'h10000, 3);
      drainMon(48, "R10");
    join
    chk(expQ.size() == 0, "R10", "std queue drained", DATA_W'(expQ.size()), 0);

    // ================= fall-through mode =================
    doReset(1);
    @(negedge wClk);
    chk(fullIr == 0, "R9", "fwft fullIr after reset", fullIr, 0);
    @(negedge rClk);
    chk(emptyOr == 1, "R9", "fwft emptyOr after reset", emptyOr, 1);
    fwftSel = 0;

    // R6: first word falls through without a read
    writeN(1, 18'h2a5a5, 0);
    begin
      bit seen;
      seen = 0;
      for (int k = 0; k < 20 && !seen; k++) begin
        @(negedge rClk);
        if (!emptyOr) begin
          seen = 1;
          chk(q == 18'h2a5a5, "R6", "q valid when ready goes low", q, 18'h2a5a5);
        end else
          chk(q == 0, "R6", "q unchanged before ready", q, 0);
      end
      chk(seen, "R6", "ready went low", DATA_W'(seen), 1);
    end

    // R7: no read, word stays
    repeat (5) @(negedge rClk);
    chk(emptyOr == 0, "R7", "ready stays low without read", emptyOr, 0);
    chk(q == 18'h2a5a5, "R7", "q holds without read", q, 18'h2a5a5);

    // R3: capacity DEPTH+1
    writeN(DEPTH - 1, 18'h04000, 0);
    chk(fullIr == 0, "R3", "no-room low after DEPTH writes", fullIr, 0);
    writeN(1, 18'h05000, 0);
    chk(fullIr == 1, "R3", "no-room high after DEPTH+1 writes", fullIr, 1);
    repeat (3) begin
      @(negedge wClk);
      din = 18'h3ffff;
      wEnN = 0;
    end
    @(negedge wClk);
    wEnN = 1;

    // R7: read-out, each read advances the head
    drainMon(DEPTH + 1, "R7");
    @(negedge rClk);
    chk(emptyOr == 1, "R3", "nothing beyond DEPTH+1 stored", emptyOr, 1);
    chk(q == lastQ, "R8", "q keeps last word", q, lastQ);

    // R8: reads while not ready are ignored
    rEnN = 0;
    repeat (4) @(negedge rClk);
    rEnN = 1;
    chk(q == lastQ, "R8", "q after extra reads", q, lastQ);
    chk(emptyOr == 1, "R8", "ready flag after extra reads", emptyOr, 1);

    // R10: overlapping traffic
    fork
      writeN(48, 18'h20000, 4);
      drainMon(48, "R10");
    join
    chk(expQ.size() == 0, "R10", "fwft queue drained", DATA_W'(expQ.size()), 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end
endmodule